// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier

This block multiplies two 12-bit symbols of GF(2^12) for Reed-Solomon arithmetic. Each symbol is treated as a degree-2 extension over GF(64). The upper six bits are one coefficient and the lower six bits are the other. The product comes from four GF(64) sub-products: a cross term in Karatsuba form, the product of the low halves, the product of the high halves, and that last product scaled by a fixed extension constant. No direct 12-bit polynomial reduction is used.

Operands arrive with a valid strobe, and the product leaves on a registered output with a matching valid strobe. A build parameter adds an operand register in front of the arithmetic. The latency is then two cycles instead of one, and the logic depth between flops is shorter. The output product register loads only when a valid result reaches it. Between results it keeps the last product.

Top module: `gf4096_mul`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and prod_o is 0x000.
- R2: The GF(64) sub-field is reduced by x^6+x+1: when both operands have zero in bits [11:6], prod_o[11:6] is 0 and prod_o[5:0] is the GF(64) product of the low halves. For example, 0x020 times 0x002 gives 0x003.
- R3: Bits [11:6] of prod_o equal (ah^al)*(bh^bl) ^ al*bl over GF(64), where ah = a[11:6], al = a[5:0], and likewise for b.
- R4: Bits [5:0] of prod_o equal ((ah*bh)*0x21) ^ al*bl over GF(64).
- R5: A product with the zero operand (on either side) is 0x000.
- R6: A product with b = 0x001 returns a unchanged.
- R7: valid_o is valid_i delayed by exactly one cycle when PIPE is 0, and by exactly two cycles when PIPE is 1.
- R8: prod_o changes only on a cycle where valid_o is 1. While valid_o is 0, it holds the last product.
- R9: Products with the generator-step element 0xE01 follow R3 and R4 for every 12-bit a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands a_i and b_i are valid |
| a_i | input | 12 | First operand, {high GF(64) half, low half} |
| b_i | input | 12 | Second operand, same layout |
| valid_o | output | 1 | prod_o carries a new product |
| prod_o | output | 12 | Product {high half, low half} |

## Verification
The bench targets the following corner cases:

- **Sub-field products.** It sweeps all 4096 sub-field pairs. A wrong reduction constant, or a reduction applied before the shift, corrupts exactly the pairs whose partial products overflow bit 5.
- **Full operand space.** It runs every 12-bit a against a set of b values: 0, 1, 0xE01, a pure high-half element, all-ones and mixed patterns. A swapped half, a missing al*bl term or a wrong extension constant breaks one half of most of those products, while 0 and 1 expose a stray cross term.
- **Pipeline variants.** It runs both pipeline variants side by side on the same stimulus, with idle gaps between results. A latency off by one, or an output register that loads without a valid result, shows up as a misaligned valid_o or a product that moves while valid_o is low.

// File: rtl/gf4096_pkg.sv
package gf4096_pkg;
  localparam int              GF_HALF_W = 6;
  localparam logic [6:0]      GF_POLY   = 7'h43;  // x^6+x+1
  localparam logic [5:0]      GF_EXT_C  = 6'h21;  // extension constant
endpackage

// File: rtl/gf_sub_mul.sv
// Combinational GF(2^W) multiply, shift-and-add unrolled over W steps.
module gf_sub_mul #(
  parameter int         W    = 6,
  parameter logic [W:0] POLY = 7'h43
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] z_o
);
  logic [W-1:0] acc [W+1];
  logic [W-1:0] mc  [W+1];

  assign acc[0] = '0;
  assign mc[0]  = y_i;

  for (genvar i = 0; i < W; i++) begin : g_step
    logic [W:0] sh;
    assign sh        = {mc[i], 1'b0};
    assign mc[i+1]   = sh[W] ? (sh[W-1:0] ^ POLY[W-1:0]) : sh[W-1:0];
    assign acc[i+1]  = acc[i] ^ (x_i[i] ? mc[i] : '0);
  end

  assign z_o = acc[W];
endmodule

// File: rtl/gf_tower_mul.sv
// GF((2^W)^2) multiply: Karatsuba cross term plus constant-scaled high product.
module gf_tower_mul #(
  parameter int         W     = 6,
  parameter logic [W:0] POLY  = 7'h43,
  parameter logic [W-1:0] EXT_C = 6'h21
) (
  input  logic [2*W-1:0] x_i,
  input  logic [2*W-1:0] y_i,
  output logic [2*W-1:0] z_o
);
  logic [W-1:0] xh, xl, yh, yl;
  logic [W-1:0] p_cross, p_low, p_high, p_ext;

  assign xh = x_i[2*W-1:W];
  assign xl = x_i[W-1:0];
  assign yh = y_i[2*W-1:W];
  assign yl = y_i[W-1:0];

  gf_sub_mul #(.W(W), .POLY(POLY)) u_cross (.x_i(xh ^ xl), .y_i(yh ^ yl), .z_o(p_cross));
  gf_sub_mul #(.W(W), .POLY(POLY)) u_low   (.x_i(xl),      .y_i(yl),      .z_o(p_low));
  gf_sub_mul #(.W(W), .POLY(POLY)) u_high  (.x_i(xh),      .y_i(yh),      .z_o(p_high));
  gf_sub_mul #(.W(W), .POLY(POLY)) u_ext   (.x_i(p_high),  .y_i(EXT_C),   .z_o(p_ext));

  assign z_o = {p_cross ^ p_low, p_ext ^ p_low};
endmodule

// File: rtl/gf4096_mul.sv
module gf4096_mul
  import gf4096_pkg::*;
#(
  parameter bit                 PIPE   = 1'b0,
  parameter int                 HALF_W = GF_HALF_W,
  parameter logic [HALF_W:0]    POLY   = GF_POLY,
  parameter logic [HALF_W-1:0]  EXT_C  = GF_EXT_C
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2*HALF_W-1:0]   a_i,
  input  logic [2*HALF_W-1:0]   b_i,
  output logic                  valid_o,
  output logic [2*HALF_W-1:0]   prod_o
);
  localparam int SYM_W = 2 * HALF_W;

  logic [SYM_W-1:0] mul_a, mul_b, mul_z;
  logic             mul_v;

  if (PIPE) begin : g_pipe
    logic [SYM_W-1:0] a_q, b_q;
    logic             v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        b_q <= '0;
        v_q <= 1'b0;
      end else begin
        v_q <= valid_i;
        if (valid_i) begin
          a_q <= a_i;
          b_q <= b_i;
        end
      end
    end
    assign mul_a = a_q;
    assign mul_b = b_q;
    assign mul_v = v_q;
  end else begin : g_flat
    assign mul_a = a_i;
    assign mul_b = b_i;
    assign mul_v = valid_i;
  end

  gf_tower_mul #(.W(HALF_W), .POLY(POLY), .EXT_C(EXT_C)) u_tower (
    .x_i(mul_a),
    .y_i(mul_b),
    .z_o(mul_z)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= mul_v;
      if (mul_v) prod_o <= mul_z;
    end
  end
endmodule

// File: rtl/gf4096_mul_chk.sv
module gf4096_mul_chk #(
  parameter bit PIPE   = 1'b0,
  parameter int HALF_W = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [2*HALF_W-1:0] a_i,
  input logic [2*HALF_W-1:0] b_i,
  input logic                valid_o,
  input logic [2*HALF_W-1:0] prod_o
);
  localparam int LAT = PIPE ? 2 : 1;

  logic                vh_q [LAT];
  logic [2*HALF_W-1:0] ah_q [LAT];
  logic [2*HALF_W-1:0] bh_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) begin
        vh_q[i] <= 1'b0;
        ah_q[i] <= '0;
        bh_q[i] <= '0;
      end
    end else begin
      vh_q[0] <= valid_i;
      ah_q[0] <= a_i;
      bh_q[0] <= b_i;
      for (int i = 1; i < LAT; i++) begin
        vh_q[i] <= vh_q[i-1];
        ah_q[i] <= ah_q[i-1];
        bh_q[i] <= bh_q[i-1];
      end
    end
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_state_chk: assert (!valid_o && prod_o == '0);
  end

  // R7
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vh_q[LAT-1]);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(prod_o));

  // R5
  zero_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (ah_q[LAT-1] == '0 || bh_q[LAT-1] == '0)) |-> prod_o == '0);

  // R6
  unit_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && bh_q[LAT-1] == 1) |-> prod_o == ah_q[LAT-1]);

  // R2
  subfield_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ah_q[LAT-1][2*HALF_W-1:HALF_W] == '0 && bh_q[LAT-1][2*HALF_W-1:HALF_W] == '0)
      |-> prod_o[2*HALF_W-1:HALF_W] == '0);
endmodule

bind gf4096_mul gf4096_mul_chk #(.PIPE(PIPE), .HALF_W(HALF_W)) u_chk (.*);

// File: tb/gf4096_mul_test.sv
module gf4096_mul_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] a_i = '0, b_i = '0;
  logic        v0, v1;
  logic [11:0] p0, p1;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  gf4096_mul #(.PIPE(1'b0)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .valid_o(v0), .prod_o(p0));
  gf4096_mul #(.PIPE(1'b1)) uut_p (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .valid_o(v1), .prod_o(p1));

  function automatic logic [5:0] m64(input logic [5:0] x, input logic [5:0] y);
    logic [5:0] acc = '0;
    logic [6:0] t;
    logic [5:0] m = y;
    for (int i = 0; i < 6; i++) begin
      if (x[i]) acc ^= m;
      t = {m, 1'b0};
      if (t[6]) t ^= 7'h43;
      m = t[5:0];
    end
    return acc;
  endfunction

  function automatic logic [11:0] ref_mul(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] ll = m64(a[5:0], b[5:0]);
    logic [5:0] hi = m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ ll;
    logic [5:0] lo = m64(m64(a[11:6], b[11:6]), 6'h21) ^ ll;
    return {hi, lo};
  endfunction

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
    end
  endtask

  // history: h1 = last driven, h2 = one before
  bit          h1_v = 0, h2_v = 0;
  logic [11:0] h1_p = '0, h2_p = '0;
  string       h1_t = "R7", h2_t = "R7";
  logic [11:0] e0 = '0, e1 = '0;

  task automatic step(input string tag, input bit v, input logic [11:0] a, input logic [11:0] b);
    @(negedge clk_i);
    if (h1_v) e0 = h1_p;
    if (h2_v) e1 = h2_p;
    chk("R7 valid_o PIPE=0", {11'd0, v0}, {11'd0, h1_v});
    chk(h1_v ? h1_t : "R8 hold PIPE=0", p0, e0);
    chk("R7 valid_o PIPE=1", {11'd0, v1}, {11'd0, h2_v});
    chk(h2_v ? h2_t : "R8 hold PIPE=1", p1, e1);
    h2_v = h1_v; h2_p = h1_p; h2_t = h1_t;
    h1_v = v; h1_p = ref_mul(a, b); h1_t = tag;
    valid_i = v; a_i = a; b_i = b;
  endtask

  initial begin
    logic [11:0] bset [10] = '{12'h000, 12'h001, 12'hE01, 12'h040, 12'h041,
                               12'hFFF, 12'h823, 12'h5A5, 12'h03F, 12'h7C0};
    repeat (3) @(negedge clk_i);
    // R1 reset state on both variants
    chk("R1 valid_o", {11'd0, v0 | v1}, 12'h000);
    chk("R1 prod_o PIPE=0", p0, 12'h000);
    chk("R1 prod_o PIPE=1", p1, 12'h000);
    rst_ni = 1'b1;

    // R2 spot: x^5 * x = x + 1
    step("R2 0x020*0x002", 1, 12'h020, 12'h002);
    if (ref_mul(12'h020, 12'h002) !== 12'h003) begin
      checks++; fails++; $display("FAIL R2 reference spot");
    end
    // R2 exhaustive sub-field sweep
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        step("R2 subfield", 1, 12'(x), 12'(y));

    // R8 idle with moving operands
    for (int k = 0; k < 4; k++) step("R8 idle", 0, 12'(k * 911), 12'hABC);
    // R7 isolated pulse then gap
    step("R7 pulse", 1, 12'h5A5, 12'h3C3);
    for (int k = 0; k < 3; k++) step("R8 after pulse", 0, 12'hFFF, 12'hFFF);

    // R3/R4 full a sweep against b set, incl. R5 zero, R6 unit, R9 0xE01
    foreach (bset[j]) begin
      for (int x = 0; x < 4096; x++) begin
        string tg;
        case (bset[j])
          12'h000: tg = "R5 zero";
          12'h001: tg = "R6 unit";
          12'hE01: tg = "R9 0xE01";
          default: tg = "R3/R4 product";
        endcase
        step(tg, (x % 97) != 13, 12'(x), bset[j]);
      end
    end
    // R5 zero on the a side, R6 unit on the a side
    for (int y = 0; y < 64; y++) step("R5 zero a", 1, 12'h000, 12'(y * 63));
    for (int y = 0; y < 64; y++) step("R6 unit a", 1, 12'h001, 12'(y * 61));
    // R3 R4 explicit spot: 0x040*0x040
    step("R3 R4 0x040*0x040", 1, 12'h040, 12'h040);
    // drain
    for (int k = 0; k < 3; k++) step("R8 drain", 0, 12'h000, 12'h000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule